// File: doc/BRIEF.md
# Power-Up Recall Sequencer and Write Guard

This block sits between the supply monitor of a battery-free non-volatile SRAM and its array control. A digital flag from the analog comparator says whether the supply is above the switch threshold. The block passes that flag through a synchroniser. Whenever the synchronised flag is low, the block arms a recall. It issues the recall request once the supply is good again, and it holds that request until the array reports that the recall has finished. Writes and stores are allowed only while the supply is good and no recall or store cycle is running.

A write may already be in progress when power returns or when a store or recall finishes. This happens when chip enable and write enable are both held low at that moment. That write must not reach the array. The block therefore latches a write lock at the completion cycle. The lock stays set until the bench or host shows a new falling edge on chip enable or write enable. Both edges are detected from registered copies of the pins, sampled on the system clock.

Top module: `pwr_recall_guard`

## Requirements
- R1: While `rst` is high and in the first cycles after reset, `recall_req`, `write_allow` and `store_allow` are all 0. The recall sequencer starts in the powered-down phase.
- R2: A rising `supply_ok` reaches the logic through a two-flop synchroniser. `recall_req` rises after the third rising clock edge that samples `supply_ok` high, and not earlier. After a drop, all three outputs are 0 after the second edge that samples `supply_ok` low.
- R3: Once raised, `recall_req` stays 1 while the supply stays good and `recall_done` is 0. A `store_done` pulse does not clear it. It clears only on an edge where `recall_done` is 1.
- R4: Every drop of the synchronised supply flag re-arms the recall. After a later return of the supply, `recall_req` is raised again.
- R5: While the synchronised supply flag is low, `write_allow`, `store_allow` and `recall_req` are 0, and a `store_start` pulse has no effect.
- R6: `store_allow` is 1 exactly when the supply is good and neither a recall nor a store cycle is active.
- R7: A `store_start` pulse while `store_allow` is 1 begins a store cycle on that edge. From then until the edge where `store_done` is 1, both `write_allow` and `store_allow` are 0.
- R8: If `ce_n` and `we_n` (both active low) are both 0 on the edge where a recall or store completes, a write lock is set and `write_allow` stays 0.
- R9: The write lock clears on an edge where `ce_n` or `we_n` is 0 and its registered copy from the previous edge is 1. `write_allow` is 1 right after that edge.
- R10: If either `ce_n` or `we_n` is 1 on the completion edge, no lock is set and `write_allow` is 1 right after completion.
- R11: When a completion with both pins low coincides with a falling edge on a pin, the lock is set. The completion wins.
- R12: A `store_start` pulse during an active recall is ignored. After the recall finishes, the block is idle with `store_allow` at 1, not in a store cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Asynchronous flag: supply above switch threshold |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| store_start | input | 1 | Pulse: a store cycle is being launched |
| store_done | input | 1 | Pulse: the store cycle has finished |
| recall_done | input | 1 | Pulse: the recall cycle has finished |
| recall_req | output | 1 | Recall request to the array sequencer |
| write_allow | output | 1 | Writes may reach the array |
| store_allow | output | 1 | Stores may be launched |

## Verification
Two actions of the block can fall on the same edge. One is setting the write lock at a completion. The other is clearing the lock on a pin falling edge. The bench raises `ce_n` for one edge. It then drives `ce_n` and `we_n` low together with the `recall_done` pulse, so that the registered copy still reads high on the completion edge. It then checks that `write_allow` stays 0, and that only a later, fresh falling edge reopens it. The bench also sweeps all four pin combinations at both recall and store completion and compares `write_allow` against the both-low rule.

// File: rtl/prg_pkg.sv
package prg_pkg;

    // Sequencer phases of the recall / store controller
    typedef enum logic [1:0] {
        PH_DOWN   = 2'd0,
        PH_RECALL = 2'd1,
        PH_IDLE   = 2'd2,
        PH_STORE  = 2'd3
    } phase_t;

    localparam int N_CTL = 2;   // chip enable and write enable
    localparam int IDX_CE = 1;
    localparam int IDX_WE = 0;

    typedef struct packed {
        logic ce_n;
        logic we_n;
    } ctl_pins_t;

    typedef struct packed {
        logic recall_fin;
        logic store_fin;
    } done_evt_t;

    function automatic logic any_done(input done_evt_t d);
        return d.recall_fin | d.store_fin;
    endfunction

    function automatic logic both_low(input ctl_pins_t p);
        return ~p.ce_n & ~p.we_n;
    endfunction

endpackage

// File: rtl/prg_sync.sv
module prg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i <= LAST; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/prg_edge.sv
module prg_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_n,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] lvl_q;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst) lvl_q[i] <= 1'b1;     // idle level of an active-low pin
                else     lvl_q[i] <= lvl_n[i];
            end
            assign fall[i] = lvl_q[i] & ~lvl_n[i];
        end
    endgenerate
endmodule

// File: rtl/prg_seq.sv
module prg_seq
    import prg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sup_s,
    input  logic      store_start,
    input  logic      store_done,
    input  logic      recall_done,
    output phase_t    phase,
    output done_evt_t done_evt
);
    phase_t phase_nx;

    always_comb begin
        phase_nx = phase;
        done_evt = '0;
        if (!sup_s) begin
            phase_nx = PH_DOWN;
        end else begin
            unique case (phase)
                PH_DOWN:   phase_nx = PH_RECALL;
                PH_RECALL: if (recall_done) begin
                    phase_nx            = PH_IDLE;
                    done_evt.recall_fin = 1'b1;
                end
                PH_IDLE:   if (store_start) phase_nx = PH_STORE;
                PH_STORE:  if (store_done) begin
                    phase_nx           = PH_IDLE;
                    done_evt.store_fin = 1'b1;
                end
                default:   phase_nx = PH_DOWN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_DOWN;
        else     phase <= phase_nx;
    end
endmodule

// File: rtl/prg_lock.sv
module prg_lock
    import prg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  done_evt_t        done_evt,
    input  ctl_pins_t        pins,
    input  logic [N_CTL-1:0] fall,
    output logic             lock
);
    always_ff @(posedge clk) begin
        if (rst)                    lock <= 1'b0;
        else if (any_done(done_evt)) lock <= both_low(pins);   // completion wins
        else if (|fall)             lock <= 1'b0;
    end
endmodule

// File: rtl/pwr_recall_guard.sv
module pwr_recall_guard
    import prg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic ce_n,
    input  logic we_n,
    input  logic store_start,
    input  logic store_done,
    input  logic recall_done,
    output logic recall_req,
    output logic write_allow,
    output logic store_allow
);
    logic             sup_s;
    phase_t           phase;
    done_evt_t        done_evt;
    ctl_pins_t        pins;
    logic [N_CTL-1:0] pin_vec;
    logic [N_CTL-1:0] fall;
    logic             wr_lock;

    assign pins.ce_n       = ce_n;
    assign pins.we_n       = we_n;
    assign pin_vec[IDX_CE] = ce_n;
    assign pin_vec[IDX_WE] = we_n;

    prg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(supply_ok), .q(sup_s)
    );

    prg_edge #(.WIDTH(N_CTL)) u_edge (
        .clk(clk), .rst(rst), .lvl_n(pin_vec), .fall(fall)
    );

    prg_seq u_seq (
        .clk(clk), .rst(rst), .sup_s(sup_s),
        .store_start(store_start), .store_done(store_done),
        .recall_done(recall_done), .phase(phase), .done_evt(done_evt)
    );

    prg_lock u_lock (
        .clk(clk), .rst(rst), .done_evt(done_evt), .pins(pins),
        .fall(fall), .lock(wr_lock)
    );

    assign recall_req  = sup_s && (phase == PH_RECALL);
    assign store_allow = sup_s && (phase == PH_IDLE);
    assign write_allow = sup_s && (phase == PH_IDLE) && !wr_lock;
endmodule

// File: rtl/pwr_recall_guard_chk.sv
module pwr_recall_guard_chk
    import prg_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   sup_s,
    input phase_t phase,
    input logic   wr_lock,
    input logic   ce_n,
    input logic   we_n,
    input logic   recall_done,
    input logic   recall_req,
    input logic   write_allow,
    input logic   store_allow
);
    AST_LOW_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !sup_s |-> (!write_allow && !store_allow && !recall_req));               // R5

    AST_REARM: assert property (@(posedge clk) disable iff (rst)
        !sup_s |=> (phase == PH_DOWN));                                           // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (recall_req && !recall_done) |=> (phase == PH_RECALL));                   // R3

    AST_STORE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STORE) |-> (!write_allow && !store_allow));                  // R7

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        wr_lock |-> !write_allow);                                                // R8

    AST_DONE_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (recall_req && recall_done && !ce_n && !we_n) |=> !write_allow);          // R11
endmodule

bind pwr_recall_guard pwr_recall_guard_chk u_chk (
    .clk(clk), .rst(rst), .sup_s(sup_s), .phase(phase), .wr_lock(wr_lock),
    .ce_n(ce_n), .we_n(we_n), .recall_done(recall_done),
    .recall_req(recall_req), .write_allow(write_allow), .store_allow(store_allow)
);

// File: tb/sim_pwr_recall_guard.sv
`timescale 1ns/1ps
module sim_pwr_recall_guard;
    logic clk = 1'b0;
    logic rst, supply_ok, ce_n, we_n, store_start, store_done, recall_done;
    logic recall_req, write_allow, store_allow;
    int   n_chk = 0;
    int   n_err = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwr_recall_guard u0 (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n),
        .store_start(store_start), .store_done(store_done), .recall_done(recall_done),
        .recall_req(recall_req), .write_allow(write_allow), .store_allow(store_allow)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // drop supply and wait until the synchronised flag is low
    task automatic power_down();
        supply_ok = 1'b0; step(); step();
    endtask

    // raise supply and wait for the recall request
    task automatic power_up();
        supply_ok = 1'b1; step(); step(); step();
    endtask

    task automatic finish_recall(input logic c, input logic w);
        ce_n = c; we_n = w; recall_done = 1'b1; step(); recall_done = 1'b0;
    endtask

    // clear any lock with a fresh chip-enable falling edge, leave pins high
    task automatic release_pins();
        ce_n = 1'b1; we_n = 1'b1; step();
        ce_n = 1'b0; step();
        ce_n = 1'b1; step();
    endtask

    initial begin
        #400000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; supply_ok = 1'b1; ce_n = 1'b1; we_n = 1'b1;
        store_start = 1'b0; store_done = 1'b0; recall_done = 1'b0;
        step(); step(); step();
        // R1: reset state, even with supply already high
        chk("R1", "recall_req in reset", recall_req, 1'b0);
        chk("R1", "write_allow in reset", write_allow, 1'b0);
        chk("R1", "store_allow in reset", store_allow, 1'b0);
        supply_ok = 1'b0;
        rst = 1'b0;
        step(); step(); step();
        chk("R1", "recall_req after reset, supply low", recall_req, 1'b0);

        // R2: synchroniser latency on the way up
        supply_ok = 1'b1;
        step(); step();
        chk("R2", "recall_req after 2 edges", recall_req, 1'b0);
        step();
        chk("R2", "recall_req after 3 edges", recall_req, 1'b1);
        chk("R6", "store_allow during recall", store_allow, 1'b0);

        // R3: request held without recall_done, store_done ignored
        for (int i = 0; i < 20; i++) begin
            store_done = (i == 5);
            step();
            chk("R3", "recall_req held", recall_req, 1'b1);
        end
        store_done = 1'b0;

        // R12: store_start during recall ignored
        store_start = 1'b1; step(); store_start = 1'b0;
        chk("R12", "recall_req after store_start", recall_req, 1'b1);
        finish_recall(1'b1, 1'b1);
        chk("R12", "store_allow after recall", store_allow, 1'b1);
        chk("R10", "write_allow after clean recall", write_allow, 1'b1);
        chk("R3", "recall_req cleared by recall_done", recall_req, 1'b0);

        // R2: latency on the way down; R5 blocking while low
        supply_ok = 1'b0; step();
        chk("R2", "write_allow 1 edge after drop", write_allow, 1'b1);
        step();
        chk("R2", "write_allow 2 edges after drop", write_allow, 1'b0);
        store_start = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R5", "store_allow while low", store_allow, 1'b0);
            chk("R5", "write_allow while low", write_allow, 1'b0);
            chk("R5", "recall_req while low", recall_req, 1'b0);
        end
        store_start = 1'b0;

        // R4: re-arm after every drop
        for (int k = 0; k < 3; k++) begin
            power_up();
            chk("R4", "recall re-armed", recall_req, 1'b1);
            power_down();
        end
        power_up();
        finish_recall(1'b1, 1'b1);

        // R8/R10: sweep pin combinations at recall completion
        for (int c = 0; c < 4; c++) begin
            power_down();
            power_up();
            finish_recall(c[1], c[0]);
            chk(((c == 0) ? "R8" : "R10"), "write_allow after recall",
                write_allow, (c != 0));
            chk("R6", "store_allow after recall", store_allow, 1'b1);
            release_pins();
            chk("R9", "write_allow after release", write_allow, 1'b1);
        end

        // R7/R8/R10: sweep pin combinations at store completion
        for (int c = 0; c < 4; c++) begin
            store_start = 1'b1; step(); store_start = 1'b0;
            for (int i = 0; i < 4; i++) begin
                chk("R7", "store_allow in store", store_allow, 1'b0);
                chk("R7", "write_allow in store", write_allow, 1'b0);
                step();
            end
            ce_n = c[1]; we_n = c[0]; store_done = 1'b1; step(); store_done = 1'b0;
            chk(((c == 0) ? "R8" : "R10"), "write_allow after store",
                write_allow, (c != 0));
            chk("R6", "store_allow after store", store_allow, 1'b1);
            release_pins();
        end

        // R9: lock held while pins stay low, cleared by write-enable fall
        power_down(); power_up();
        finish_recall(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R8", "lock holds while pins low", write_allow, 1'b0);
        end
        we_n = 1'b1; step();
        chk("R9", "rising edge does not clear", write_allow, 1'b0);
        we_n = 1'b0; step();
        chk("R9", "we_n fall clears lock", write_allow, 1'b1);
        release_pins();

        // R11: completion coincides with a falling edge
        power_down(); power_up();
        ce_n = 1'b1; we_n = 1'b1; step();
        finish_recall(1'b0, 1'b0);   // ce_n falls on the completion edge
        chk("R11", "completion beats fall", write_allow, 1'b0);
        step();
        chk("R11", "lock still held", write_allow, 1'b0);
        ce_n = 1'b1; step();
        ce_n = 1'b0; step();
        chk("R11", "fresh fall clears lock", write_allow, 1'b1);

        finish_run();
    end
endmodule